// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block gathers 32 interrupt inputs, turns each into a pending condition and steers every pending, enabled source to any of sixteen interrupt request lines, arranged as four lines on each of four cores. Each source can be level-sensitive or edge-sensitive, and a per-source polarity bit picks the active level or the active edge. The inputs may be asynchronous. They pass through a two-flop synchronizer before any detection.

Software drives a simple register bus with a byte address, 32-bit write data, a write strobe and four byte-lane enables. Read data is combinational from the address. Each source owns one route byte. The low nibble of that byte picks cores, one bit per core, and the high nibble picks request lines, one bit per line. Sources are switched on through a write-ones-to-set register and switched off through a separate write-ones-to-clear register. A write to the clear register also discards any edge that the source has already captured. Software scans the pending word from bit 0 upward when it services requests.

Top module: `rirq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the enable word (0x24), the polarity word (0x30), the edge-mode word (0x34), every route byte and every irq_out line read as zero.
- R2: The route byte for source i sits at byte offset i (0x00 to 0x1F). A word read at offset 4k returns source 4k in bits 7:0, source 4k+1 in bits 15:8, source 4k+2 in bits 23:16 and source 4k+3 in bits 31:24. A write updates only the byte lanes whose bus_be bit is set.
- R3: Writing to 0x28 sets the enable bits that are 1 in the data. Bits that are 0 in the data leave their enables unchanged. The enable mask reads back at 0x24.
- R4: Writing to 0x2C clears the enable bits that are 1 in the data. Writing all ones disables every source.
- R5: With edge-mode bit 0, a source is pending while its synchronized input equals its polarity bit. Polarity 1 means active-high and polarity 0 means active-low.
- R6: With edge-mode bit 1, a rising edge (polarity 1) or a falling edge (polarity 0) sets a pending latch. The latch stays set after the input returns to its idle level.
- R7: A 1 written for a source at 0x2C also clears that source's edge latch. The clear wins over an edge detected in the same cycle.
- R8: Offset 0x40 reads the pending state of all 32 sources, whether or not they are enabled.
- R9: irq_out[4*c+p] is the registered OR of every enabled, pending source whose route byte has bit c (core c) and bit 4+p (line p) set.
- R10: A level change on irq_in reaches irq_out on the third rising clock edge after it is applied (two synchronizer stages plus the output register).
- R11: A disabled source never drives any irq_out line, even when it is pending.
- R12: Register writes apply only with bus_addr[1:0] equal to 00, and only to the byte lanes enabled by bus_be. This holds for the polarity, edge-mode, set and clear words as well as the route words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_in | input | 32 | Raw interrupt inputs, may be asynchronous |
| irq_out | output | 16 | Request lines, index 4*core+line, registered |

## Verification
The checker watches several properties on every cycle. A set write raises every selected enable bit and leaves the unselected bits alone. A clear write drops both the selected enables and their edge latches. The outputs stay silent in any cycle after one in which nothing is enabled or no route byte is non-zero. Other behaviour can only be shown by the bench scenarios: the exact mapping from route bits to output index, level and edge decoding under each polarity, the three-edge latency, byte-lane writes, and the pending word that is visible while sources are disabled.

// File: rtl/rirq_pkg.sv
// Shared constants for the routed interrupt controller.
// Assumes a byte-addressed register bus with 32-bit words.
package rirq_pkg;
    localparam int ROUTE_W  = 8;  // width of one route byte
    localparam int LINE_LSB = 4;  // route bits [7:4] pick request lines, [3:0] pick cores

    // Word indices (byte address >> 2) of the control words
    localparam logic [5:0] W_EN_RD  = 6'h09;  // 0x24 enable mask (read)
    localparam logic [5:0] W_EN_SET = 6'h0A;  // 0x28 write ones to set
    localparam logic [5:0] W_EN_CLR = 6'h0B;  // 0x2C write ones to clear
    localparam logic [5:0] W_POL    = 6'h0C;  // 0x30 polarity
    localparam logic [5:0] W_EDGE   = 6'h0D;  // 0x34 edge mode
    localparam logic [5:0] W_STAT   = 6'h10;  // 0x40 pending status
endpackage

// File: rtl/rirq_regs.sv
// Register file: route bytes, enable mask, polarity and edge-mode words.
// Assumes NSRC == 32 (one bus word per mask) and NSRC a multiple of 4.
// Writes with a misaligned address are dropped; reads are combinational.
module rirq_regs
    import rirq_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [7:0]              addr,
    input  logic [3:0]              be,
    input  logic [31:0]             wdata,
    input  logic [NSRC-1:0]         status_i,
    output logic [31:0]             rdata,
    output logic [NSRC*ROUTE_W-1:0] route_o,
    output logic [NSRC-1:0]         en_o,
    output logic [NSRC-1:0]         pol_o,
    output logic [NSRC-1:0]         edge_o,
    output logic [NSRC-1:0]         clr_o
);
    localparam int NRWORD = NSRC / 4;

    logic [ROUTE_W-1:0] route_q [NSRC];
    logic [NSRC-1:0]    en_q, pol_q, edge_q;
    logic [5:0]         word;
    logic               wr_ok;
    logic [31:0]        lane_m;
    logic [NSRC-1:0]    wmask;

    assign word   = addr[7:2];
    assign wr_ok  = wr && (addr[1:0] == 2'b00);
    assign lane_m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    assign wmask  = wdata[NSRC-1:0] & lane_m[NSRC-1:0];

    // One route byte per source, written through its own byte lane
    for (genvar i = 0; i < NSRC; i++) begin : g_route
        always_ff @(posedge clk) begin
            if (!rst_n)
                route_q[i] <= '0;
            else if (wr_ok && word == 6'(i / 4) && be[i % 4])
                route_q[i] <= wdata[(i % 4)*ROUTE_W +: ROUTE_W];
        end
        assign route_o[i*ROUTE_W +: ROUTE_W] = route_q[i];
    end

    // Enable mask: set and clear through separate words
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_ok && word == W_EN_SET)
            en_q <= en_q | wmask;
        else if (wr_ok && word == W_EN_CLR)
            en_q <= en_q & ~wmask;
    end

    // Polarity and edge-mode words, byte-lane masked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= '0;
            edge_q <= '0;
        end else if (wr_ok && word == W_POL) begin
            pol_q  <= (pol_q & ~lane_m[NSRC-1:0]) | wmask;
        end else if (wr_ok && word == W_EDGE) begin
            edge_q <= (edge_q & ~lane_m[NSRC-1:0]) | wmask;
        end
    end

    // Pulse of the bits written to the clear word, used to drop edge latches
    assign clr_o = (wr_ok && word == W_EN_CLR) ? wmask : '0;

    assign en_o   = en_q;
    assign pol_o  = pol_q;
    assign edge_o = edge_q;

    // Read multiplexer
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NRWORD; k++) begin
            if (word == 6'(k))
                rdata = {route_q[4*k+3], route_q[4*k+2], route_q[4*k+1], route_q[4*k]};
        end
        case (word)
            W_EN_RD: rdata = 32'(en_q);
            W_POL:   rdata = 32'(pol_q);
            W_EDGE:  rdata = 32'(edge_q);
            W_STAT:  rdata = 32'(status_i);
            default: ;
        endcase
    end
endmodule

// File: rtl/rirq_detect.sv
// Per-source pending logic: two-flop synchronizer, level compare and edge latch.
// Assumes irq_i may be asynchronous; clr_i is a one-cycle pulse per bit.
module rirq_detect #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_i,
    input  logic [NSRC-1:0] pol_i,
    input  logic [NSRC-1:0] edge_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o
);
    logic [NSRC-1:0] s1_q, s2_q, prev_q, latch_q;
    logic [NSRC-1:0] lvl_hit, rise, fall, edge_hit;

    // Synchronize inputs and keep the previous sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= '0;
            s2_q   <= '0;
            prev_q <= '0;
        end else begin
            s1_q   <= irq_i;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign lvl_hit  = ~(s2_q ^ pol_i);
    assign rise     = s2_q & ~prev_q;
    assign fall     = ~s2_q & prev_q;
    assign edge_hit = (pol_i & rise) | (~pol_i & fall);

    // Edge latch: set on the chosen edge, clear wins, held empty outside edge mode
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else
            latch_q <= (latch_q | edge_hit) & ~clr_i & edge_i;
    end

    assign pend_o = (edge_i & latch_q) | (~edge_i & lvl_hit);
endmodule

// File: rtl/rirq_fanout.sv
// Routes active sources to core/line request outputs via registered AND-OR trees.
// Assumes NCORE <= 4 and NLINE <= 4 so both fit one route byte.
module rirq_fanout
    import rirq_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NCORE = 4,
    parameter int NLINE = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSRC-1:0]         active_i,
    input  logic [NSRC*ROUTE_W-1:0] route_i,
    output logic [NCORE*NLINE-1:0]  irq_o
);
    logic [NCORE-1:0][NSRC-1:0] core_sel;
    logic [NLINE-1:0][NSRC-1:0] line_sel;

    // Regroup route bits into per-core and per-line source masks
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        for (genvar c = 0; c < NCORE; c++) begin : g_core
            assign core_sel[c][i] = route_i[i*ROUTE_W + c];
        end
        for (genvar p = 0; p < NLINE; p++) begin : g_line
            assign line_sel[p][i] = route_i[i*ROUTE_W + LINE_LSB + p];
        end
    end

    // Register one OR-reduction per (core, line) pair
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= '0;
        else
            for (int c = 0; c < NCORE; c++)
                for (int p = 0; p < NLINE; p++)
                    irq_o[c*NLINE + p] <= |(active_i & core_sel[c] & line_sel[p]);
    end
endmodule

// File: rtl/rirq_ctrl.sv
// Top of the routed local interrupt controller.
// Assumes a single clock domain for the bus; irq_in may be asynchronous.
module rirq_ctrl
    import rirq_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NCORE = 4,
    parameter int NLINE = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [7:0]             bus_addr,
    input  logic [3:0]             bus_be,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NSRC-1:0]        irq_in,
    output logic [NCORE*NLINE-1:0] irq_out
);
    logic [NSRC*ROUTE_W-1:0] route_q;
    logic [NSRC-1:0]         en_q, pol_q, edge_q, clr_pulse, pend;

    // Software-visible registers
    rirq_regs #(.NSRC(NSRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .be(bus_be),
        .wdata(bus_wdata), .status_i(pend), .rdata(bus_rdata), .route_o(route_q),
        .en_o(en_q), .pol_o(pol_q), .edge_o(edge_q), .clr_o(clr_pulse)
    );

    // Pending detection
    rirq_detect #(.NSRC(NSRC)) u_detect (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_in), .pol_i(pol_q),
        .edge_i(edge_q), .clr_i(clr_pulse), .pend_o(pend)
    );

    // Routing to request lines, gated by the enable mask
    rirq_fanout #(.NSRC(NSRC), .NCORE(NCORE), .NLINE(NLINE)) u_fanout (
        .clk(clk), .rst_n(rst_n), .active_i(pend & en_q),
        .route_i(route_q), .irq_o(irq_out)
    );
endmodule

// File: rtl/rirq_chk.sv
// Temporal checks on the routed interrupt controller, attached by bind.
// Assumes full-word, aligned writes for the enable-word properties.
module rirq_chk #(
    parameter int NSRC  = 32,
    parameter int NCORE = 4,
    parameter int NLINE = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_wr,
    input logic [7:0]             bus_addr,
    input logic [3:0]             bus_be,
    input logic [31:0]            bus_wdata,
    input logic [NCORE*NLINE-1:0] irq_out,
    input logic [NSRC-1:0]        en_mask,
    input logic [NSRC*8-1:0]      route_all,
    input logic [NSRC-1:0]        edge_mode,
    input logic [NSRC-1:0]        status
);
    logic set_wr, clr_wr;
    assign set_wr = bus_wr && bus_addr == 8'h28 && bus_be == 4'hF;
    assign clr_wr = bus_wr && bus_addr == 8'h2C && bus_be == 4'hF;

    // R3
    en_set_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((en_mask & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

    // R3
    en_set_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((en_mask & ~$past(bus_wdata[NSRC-1:0])) ==
                    ($past(en_mask) & ~$past(bus_wdata[NSRC-1:0]))));

    // R4
    en_clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((en_mask & $past(bus_wdata[NSRC-1:0])) == '0));

    // R7
    latch_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((status & edge_mode & $past(bus_wdata[NSRC-1:0])) == '0));

    // R11
    no_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_mask == '0) |=> (irq_out == '0));

    // R9
    no_route_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route_all == '0) |=> (irq_out == '0));
endmodule

bind rirq_ctrl rirq_chk #(.NSRC(NSRC), .NCORE(NCORE), .NLINE(NLINE)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .irq_out(irq_out),
    .en_mask(en_q), .route_all(route_q), .edge_mode(edge_q), .status(pend)
);

// File: tb/rirq_ctrl_bench.sv
`timescale 1ns/1ps
module rirq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in;
    logic [15:0] irq_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rirq_ctrl u_rirq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    typedef struct packed {
        logic [31:0] src;
        logic [15:0] out;
    } vec_t;

    // Route of source i: core i%4, line (i/4)%4, output index 4*core+line
    localparam vec_t VECS [8] = '{
        '{32'h0000_0000, 16'h0000},
        '{32'h0000_0001, 16'h0001},
        '{32'h0000_0002, 16'h0010},
        '{32'h0000_0004, 16'h0100},
        '{32'h0000_0010, 16'h0002},
        '{32'h8000_0000, 16'h8000},
        '{32'h0001_0021, 16'h0021},
        '{32'hFFFF_FFFF, 16'hFFFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'h0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0; irq_in = '0;
        settle(3);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq_out", 32'(irq_out), 32'h0);
        rd(8'h24, d); chk("R1 enable", d, 32'h0);
        rd(8'h30, d); chk("R1 polarity", d, 32'h0);
        rd(8'h34, d); chk("R1 edge", d, 32'h0);
        rd(8'h00, d); chk("R1 route0", d, 32'h0);
        rd(8'h1C, d); chk("R1 route7", d, 32'h0);

        // R5 default level-low, R8 visible while disabled
        settle(3);
        rd(8'h40, d); chk("R5 R8 level-low pending", d, 32'hFFFF_FFFF);

        // R2 route configuration and readback
        for (int k = 0; k < 8; k++) begin
            logic [31:0] w;
            for (int j = 0; j < 4; j++)
                w[j*8 +: 8] = 8'((1 << (4 + (k % 4))) | (1 << j));
            wr(8'(4*k), w, 4'hF);
        end
        rd(8'h00, d); chk("R2 route word0", d, 32'h1814_1211);
        rd(8'h1C, d); chk("R2 route word7", d, 32'h8884_8281);

        // R12 byte lane write of one route byte
        wr(8'h04, 32'hAABB_CCDD, 4'b0010);
        rd(8'h04, d); chk("R12 R2 single lane", d, 32'h2824_CC21);
        wr(8'h06, 32'hFFFF_FFFF, 4'hF);
        rd(8'h04, d); chk("R12 misaligned ignored", d, 32'h2824_CC21);
        wr(8'h04, 32'h2824_2221, 4'hF);

        // R3 / R4 enable set and clear
        wr(8'h28, 32'h0000_00F0, 4'hF);
        wr(8'h28, 32'h0000_0F00, 4'hF);
        rd(8'h24, d); chk("R3 set accumulates", d, 32'h0000_0FF0);
        wr(8'h2C, 32'h0000_00F0, 4'hF);
        rd(8'h24, d); chk("R4 clear selected", d, 32'h0000_0F00);
        wr(8'h2C, 32'hFFFF_FFFF, 4'hF);
        rd(8'h24, d); chk("R4 clear all", d, 32'h0);

        // R11 disabled sources pending but silent, R8 status
        wr(8'h30, 32'hFFFF_FFFF, 4'hF);
        irq_in = 32'hFFFF_FFFF;
        settle(5);
        chk("R11 disabled quiet", 32'(irq_out), 32'h0);
        rd(8'h40, d); chk("R8 status while disabled", d, 32'hFFFF_FFFF);
        irq_in = '0;
        settle(4);

        // R9 routing table
        wr(8'h28, 32'hFFFF_FFFF, 4'hF);
        foreach (VECS[n]) begin
            @(negedge clk);
            irq_in = VECS[n].src;
            settle(4);
            chk("R9 route vector", 32'(irq_out), 32'(VECS[n].out));
        end
        irq_in = '0;
        settle(5);

        // R10 latency: output rises on the third edge
        @(negedge clk);
        irq_in = 32'h1;
        settle(2);
        chk("R10 not before third edge", 32'(irq_out), 32'h0);
        settle(1);
        chk("R10 on third edge", 32'(irq_out), 32'h1);
        irq_in = '0;
        settle(5);

        // R5 level-low on source 0
        wr(8'h30, 32'hFFFF_FFFE, 4'hF);
        settle(4);
        chk("R5 level-low active", 32'(irq_out), 32'h1);
        irq_in = 32'h1;
        settle(4);
        chk("R5 level-low idle", 32'(irq_out), 32'h0);
        irq_in = '0;

        // R6 edge mode: source 3 rising, source 7 falling
        wr(8'h30, 32'hFFFF_FF7F, 4'hF);
        wr(8'h34, 32'h0000_0088, 4'hF);
        settle(5);
        rd(8'h40, d); chk("R6 no edge yet", d, 32'h0);
        irq_in = 32'h8;
        settle(2);
        irq_in = 32'h0;
        settle(6);
        rd(8'h40, d); chk("R6 rising latched", d, 32'h8);
        chk("R6 rising output", 32'(irq_out), 32'h1000);
        irq_in = 32'h80;
        settle(5);
        rd(8'h40, d); chk("R6 rise ignored in falling mode", d, 32'h8);
        irq_in = 32'h0;
        settle(5);
        rd(8'h40, d); chk("R6 falling latched", d, 32'h88);
        chk("R6 both outputs", 32'(irq_out), 32'h3000);

        // R7 clear drops latch and enable
        wr(8'h2C, 32'h0000_0008, 4'hF);
        settle(3);
        rd(8'h40, d); chk("R7 latch cleared", d, 32'h80);
        rd(8'h24, d); chk("R7 enable dropped", d, 32'hFFFF_FFF7);
        chk("R7 output after clear", 32'(irq_out), 32'h2000);
        wr(8'h2C, 32'h0000_0080, 4'hF);
        settle(3);
        rd(8'h40, d); chk("R7 second latch cleared", d, 32'h0);
        chk("R7 outputs quiet", 32'(irq_out), 32'h0);

        // R1 reset mid-run
        irq_in = 32'hFFFF_FFFF;
        @(negedge clk); rst_n = 1'b0;
        settle(2);
        rst_n = 1'b1;
        chk("R1 output after reset", 32'(irq_out), 32'h0);
        rd(8'h24, d); chk("R1 enable after reset", d, 32'h0);
        rd(8'h10, d); chk("R1 route after reset", d, 32'h0);
        rd(8'h34, d); chk("R1 edge after reset", d, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule